// File: doc/BRIEF.md
# Cascaded Half-Step Strobe Divider

This block turns the core clock into a periodic single-cycle sample strobe. Two rate stages sit in series. The first stage counts core clock cycles. The second stage counts the pulses that the first stage emits. The strobe therefore repeats at the core rate divided by the product of the two stage divisors.

Each stage takes a 5-bit code and divides by (code + 2) / 2. That gives divisors from 1 to 16 in half steps. A half-step divisor is made by alternating short and long periods, so the long-run average is exact. For example, from a 200 MHz core clock the code pair (17h, 02h) gives 8 MHz and the pair (12h, 00h) gives 20 MHz.

A code change does not disturb the period in progress. It is taken up when the next strobe is produced, and both stages then start counting afresh. Lowering enable stops the strobe and clears both stages.

Top module: `cascade_halfstep_div`

## Requirements
- R1: A stage code c in 00h..1Eh selects the divisor (c + 2) / 2. For example, code 05h divides by 3.5 and code 1Dh divides by 15.5.
- R2: With both stages running and unchanged codes, the average strobe period in core cycles equals the product of the two stage divisors. The pairs (17h,02h), (12h,02h), (17h,00h) and (12h,00h) give periods of 25, 20, 12.5 and 10.
- R3: Code 00h makes a stage pass every input pulse straight through. With both codes at 00h, the strobe is high on every cycle while enabled.
- R4: A stage divisor of N + 0.5 gives output periods that alternate between N + 1 and N input pulses, beginning with N + 1 after a restart.
- R5: The second stage counts first-stage pulses, not core cycles. With codes (03h, 02h), every strobe period is exactly 5 cycles.
- R6: A code change applied mid-period leaves the current period at the old divisor. On the strobe that ends that period, both stages restart from zero with the new codes.
- R7: Any code above 1Eh acts as 1Eh, which is a divisor of 16.
- R8: While enable is low, strobe_o stays low and both stages are held at zero. After enable rises, the first strobe arrives once a full period has elapsed.
- R9: strobe_o is registered. It is high in the cycle after the clock edge on which the final stage completes its count, and it is low during and straight after a synchronous active-low reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable_i | input | 1 | Run control; low holds both stages cleared |
| div0_code_i | input | 5 | First-stage code, divisor = (code + 2) / 2 |
| div1_code_i | input | 5 | Second-stage code, divisor = (code + 2) / 2 |
| strobe_o | output | 1 | Single-cycle sample strobe |

## Verification
The assertions treat any 5-bit code as legal. They take for granted only that enable and the codes are synchronous to the core clock and stay steady around its rising edge. They also assume that the active codes can change only while the block is idle or on a restart strobe. The bench changes enable and codes only on the falling clock edge. It loads new codes while enable is low, except in the mid-period change case. The bench's reference model counts pulses per stage and divides integers. It compares the strobe on every cycle, while windowed counts and interval checks cover average rates and the alternation pattern.

// File: rtl/hsd_pkg.sv
// Package: shared widths, code limits and code helpers for the
// cascaded half-step divider. Assumes 5-bit stage codes.
package hsd_pkg;
    localparam int CODE_W   = 5;
    localparam int MAX_CODE = 30;
    localparam int TWICE_W  = CODE_W + 1;

    typedef logic [CODE_W-1:0]  code_t;
    typedef logic [TWICE_W-1:0] twice_t;

    // Limit a raw code to the largest legal divisor code.
    function automatic code_t clamp_code(input code_t c);
        return (int'(c) > MAX_CODE) ? code_t'(MAX_CODE) : c;
    endfunction

    // Twice the divisor, in half-cycle units: code + 2.
    function automatic twice_t twice_of(input code_t c);
        return twice_t'(c) + twice_t'(2);
    endfunction
endpackage

// File: rtl/hsd_stage.sv
// Module: one half-step rate stage. Each input pulse adds two half units
// to a residue. When the sum reaches twice the divisor, the stage fires
// (combinationally, on the same cycle as the input pulse) and keeps the
// remainder. Assumes twice_div_i changes only while run_i is low or
// together with restart_i.
module hsd_stage
    import hsd_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   run_i,
    input  logic   restart_i,
    input  logic   pulse_i,
    input  twice_t twice_div_i,
    output logic   fire_o
);
    localparam int ACC_W = TWICE_W + 1;

    logic [ACC_W-1:0] acc_q;
    logic [ACC_W-1:0] sum;
    logic [ACC_W-1:0] limit;

    assign sum    = acc_q + ACC_W'(2);
    assign limit  = {1'b0, twice_div_i};
    assign fire_o = pulse_i && (sum >= limit);

    // Residue update: clear when idle or on restart, else accumulate.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else if (!run_i || restart_i) begin
            acc_q <= '0;
        end else if (pulse_i) begin
            acc_q <= fire_o ? (sum - limit) : sum;
        end
    end

    // R4: the residue always stays below one full divisor.
    p_residue_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        acc_q < limit);

    // R3: a unit divisor fires on every input pulse.
    p_unit_pass_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (twice_div_i == twice_t'(2) && pulse_i) |-> fire_o);
endmodule

// File: rtl/hsd_code_ctrl.sv
// Module: active-code holder. It clamps the raw codes. While idle it tracks
// them. While running it holds them until a final-stage boundary and then
// takes up any changed code, raising restart for the stages.
module hsd_code_ctrl
    import hsd_pkg::*;
#(
    parameter int N_STAGES = 2
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  run_i,
    input  logic  boundary_i,
    input  code_t raw_i [N_STAGES],
    output code_t act_o [N_STAGES],
    output logic  restart_o
);
    code_t               act_q   [N_STAGES];
    code_t               clamped [N_STAGES];
    logic [N_STAGES-1:0] differs;

    assign restart_o = boundary_i && (|differs);

    for (genvar g = 0; g < N_STAGES; g++) begin : g_code
        assign clamped[g] = clamp_code(raw_i[g]);
        assign differs[g] = (clamped[g] != act_q[g]);
        assign act_o[g]   = act_q[g];

        // Load a code while idle, or at a boundary that carries a change.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                act_q[g] <= '0;
            end else if (!run_i || restart_o) begin
                act_q[g] <= clamped[g];
            end
        end

        // R7: an active code never exceeds the largest legal code.
        p_code_limit_r7: assert property (@(posedge clk) disable iff (!rst_n)
            int'(act_q[g]) <= MAX_CODE);

        // R6: while running, the code holds except at a boundary.
        p_code_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (run_i && !boundary_i) |=> $stable(act_q[g]));
    end
endmodule

// File: rtl/cascade_halfstep_div.sv
// Module: top of the cascaded half-step divider. It chains two rate stages,
// first stage fed by enable, and registers the last stage's fire as the
// strobe. Assumes all inputs are synchronous to clk.
module cascade_halfstep_div
    import hsd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable_i,
    input  logic [CODE_W-1:0] div0_code_i,
    input  logic [CODE_W-1:0] div1_code_i,
    output logic              strobe_o
);
    localparam int N_STAGES = 2;

    code_t             raw     [N_STAGES];
    code_t             act     [N_STAGES];
    twice_t            twice   [N_STAGES];
    logic [N_STAGES:0] pulse;
    logic              restart;
    logic              strobe_q;

    assign raw[0]   = div0_code_i;
    assign raw[1]   = div1_code_i;
    assign pulse[0] = enable_i;

    hsd_code_ctrl #(.N_STAGES(N_STAGES)) code_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .run_i      (enable_i),
        .boundary_i (pulse[N_STAGES]),
        .raw_i      (raw),
        .act_o      (act),
        .restart_o  (restart)
    );

    for (genvar g = 0; g < N_STAGES; g++) begin : g_stage
        assign twice[g] = twice_of(act[g]);
        hsd_stage stage_i (
            .clk         (clk),
            .rst_n       (rst_n),
            .run_i       (enable_i),
            .restart_i   (restart),
            .pulse_i     (pulse[g]),
            .twice_div_i (twice[g]),
            .fire_o      (pulse[g+1])
        );
    end

    // Register the final-stage fire as the output strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) strobe_q <= 1'b0;
        else        strobe_q <= enable_i && pulse[N_STAGES];
    end

    assign strobe_o = strobe_q;

    // R8: no strobe in the cycle after enable was low.
    p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !enable_i |=> !strobe_o);
endmodule

// File: tb/cascade_halfstep_div_tb_top.sv
// Bench: a behavioural pulse-count model compared on every falling edge,
// plus windowed rate counts and interval checks.
module cascade_halfstep_div_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enable = 1'b0;
    logic [4:0] c0 = '0;
    logic [4:0] c1 = '0;
    logic       strobe;

    int    checks = 0;
    int    failures = 0;
    bit    done = 1'b0;
    string phase = "R9";

    always #(CLK_PERIOD/2) clk = ~clk;

    cascade_halfstep_div dut_i (
        .clk(clk), .rst_n(rst_n), .enable_i(enable),
        .div0_code_i(c0), .div1_code_i(c1), .strobe_o(strobe)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int lim(input int c);
        return (c > 30) ? 30 : c;
    endfunction

    // Reference model: pulse counts per stage, fire when floor(2k/T) steps up.
    int m_k1 = 0, m_k2 = 0, m_a0 = 0, m_a1 = 0;
    bit m_exp = 1'b0;
    always @(posedge clk) begin
        if (!rst_n) begin
            m_k1 = 0; m_k2 = 0; m_a0 = 0; m_a1 = 0; m_exp = 1'b0;
        end else if (!enable) begin
            m_k1 = 0; m_k2 = 0; m_a0 = lim(c0); m_a1 = lim(c1); m_exp = 1'b0;
        end else begin
            int t0, t1;
            bit f1, f2;
            t0 = m_a0 + 2;
            t1 = m_a1 + 2;
            m_k1++;
            f1 = ((2*m_k1)/t0) != ((2*(m_k1-1))/t0);
            f2 = 1'b0;
            if (f1) begin
                m_k2++;
                f2 = ((2*m_k2)/t1) != ((2*(m_k2-1))/t1);
            end
            m_exp = f2;
            if (f2 && (lim(c0) != m_a0 || lim(c1) != m_a1)) begin
                m_a0 = lim(c0); m_a1 = lim(c1); m_k1 = 0; m_k2 = 0;
            end
        end
    end

    // Compare the strobe with the model on every falling edge.
    always @(negedge clk) begin
        if (!done) check(strobe === m_exp, {phase, " model"}, int'(strobe), int'(m_exp));
    end

    // Load codes while idle, then enable on a falling edge.
    task automatic start_run(input logic [4:0] a, input logic [4:0] b);
        @(negedge clk); enable = 1'b0; c0 = a; c1 = b;
        @(negedge clk); @(negedge clk); enable = 1'b1;
    endtask

    task automatic window(input int n, input int exp, input string tag);
        int cnt;
        cnt = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (strobe) cnt++;
        end
        check(cnt == exp, tag, cnt, exp);
    endtask

    // Intervals: first is e_first, then odd-indexed e_odd, even-indexed e_even.
    task automatic intervals(input int n, input int e_first, input int e_odd,
                             input int e_even, input string tag);
        int gap;
        for (int i = 0; i < n; i++) begin
            int e;
            gap = 0;
            do begin @(negedge clk); gap++; end while (!strobe && gap < 1000);
            e = (i == 0) ? e_first : ((i % 2) == 1 ? e_odd : e_even);
            check(gap == e, tag, gap, e);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(strobe == 1'b0, "R9 reset", int'(strobe), 0);
        rst_n = 1'b1;

        phase = "R3"; start_run(5'h00, 5'h00);
        window(20, 20, "R3 every cycle");

        phase = "R8"; enable = 1'b0;
        window(10, 0, "R8 idle quiet");

        phase = "R2";
        start_run(5'h17, 5'h02); window(500, 20, "R2 period 25");
        start_run(5'h12, 5'h02); window(500, 25, "R2 period 20");
        start_run(5'h17, 5'h00); window(500, 40, "R2 period 12.5");
        start_run(5'h12, 5'h00); window(500, 50, "R2 period 10");

        phase = "R1";
        start_run(5'h05, 5'h00); window(70, 20, "R1 divisor 3.5");
        start_run(5'h1D, 5'h00); window(155, 10, "R1 divisor 15.5");

        phase = "R4"; start_run(5'h03, 5'h00);
        intervals(6, 3, 2, 3, "R4 alternation");

        phase = "R5"; start_run(5'h03, 5'h02);
        intervals(5, 5, 5, 5, "R5 counts stage pulses");

        phase = "R7";
        start_run(5'h1F, 5'h00); window(160, 10, "R7 clamp stage0");
        start_run(5'h00, 5'h1F); window(160, 10, "R7 clamp stage1");

        phase = "R6"; start_run(5'h08, 5'h00);
        begin
            int gap;
            gap = 0;
            do begin @(negedge clk); gap++; end while (!strobe && gap < 1000);
            @(negedge clk); @(negedge clk);
            c0 = 5'h02;
            gap = 2;
            do begin @(negedge clk); gap++; end while (!strobe && gap < 1000);
            check(gap == 5, "R6 old period kept", gap, 5);
            gap = 0;
            do begin @(negedge clk); gap++; end while (!strobe && gap < 1000);
            check(gap == 2, "R6 new period after restart", gap, 2);
        end

        enable = 1'b0;
        @(negedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(CLK_PERIOD * WATCHDOG);
        if (!done) begin
            done = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", WATCHDOG, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule